// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing frames from system memory to a byte-wide transmit port. Software builds a list of descriptors in memory. Each descriptor takes eight 32-bit words, and the engine uses only the first four. Word 0 holds control flags and, after processing, the returned status. Word 1 holds the buffer length in bytes, word 2 the buffer address, and word 3 an optional link to the next descriptor. The engine waits in a suspended state until the host pulses a poll request. It then reads a descriptor and checks the ownership flag. If the engine owns the descriptor, it streams the buffer to the transmit port one byte per accepted handshake. It then writes word 0 back with ownership returned to the host and moves on to the next descriptor.

A frame may span several descriptors (scatter-gather). The first-segment flag places the start-of-frame marker and the last-segment flag places the end-of-frame marker. On the last segment the engine waits for a status word from the transmitter, merges it into the write-back and, if requested, raises a one-cycle interrupt. An empty buffer met in the middle of a frame aborts the frame, reports an underflow and suspends the engine.

Top module: `txdma_engine`

## Requirements
- R1: A descriptor is processed only when word 0 bit 31 is 1 (DMA-owned). If bit 31 is 0, the engine makes no further memory access and waits with memReq low. A pollReq pulse makes it re-read word 0 at the same address. While a memory request waits for memAck, memReq, memAddr and memWe hold steady.
- R2: For a descriptor with a non-zero length (word 1 bits 12:0), exactly that many bytes are sent from the word-aligned buffer at word 2. Within each 32-bit word the low byte goes first. While txValid is high and txReady is low, txData and txLast hold steady.
- R3: txFirst is high only on the first byte sent after a descriptor with word 0 bit 28 set. txLast is high only on the final byte of a descriptor with word 0 bit 29 set.
- R4: Write-back rewrites word 0 as follows. Bit 31 is cleared and bits 30:17 are kept. Bits 16 and 14:0 carry the transmitter status (txStatBits, taken only for a last segment; zero otherwise).
- R5: Write-back bit 15 equals the OR of status bits 16, 14, 13, 12, 11, 10, 9, 8, 2 and 1. Bits 7:3 and 0 do not affect it.
- R6: txIrq pulses for one cycle after the write-back of a descriptor that has both bit 30 and bit 29 set. Bit 30 on a descriptor without bit 29 raises no interrupt.
- R7: The next descriptor address is chosen in this order. If bit 21 is set, it is listBase. Otherwise, if bit 20 is set, it is word 3. Otherwise it is the current address plus 32.
- R8: A descriptor with zero length and either bit 28 clear or bit 29 set is an underflow. No byte is sent and txAbort pulses. The write-back has bits 1 and 15 set and txIrq pulses. The engine then suspends, and the next poll resumes at the following descriptor.
- R9: After reset the engine is suspended at listBase, with memReq, txValid and txIrq low, until the first poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| listBase | input | 32 | Byte address of the first descriptor; ring wrap target |
| pollReq | input | 1 | Poll pulse: leave Suspended and fetch the current descriptor |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word accessed |
| memWData | output | 32 | Write data (descriptor word 0 write-back) |
| memAck | input | 1 | Request completed; read data valid in the same cycle |
| memRData | input | 32 | Read data |
| txValid | output | 1 | Byte on txData is valid |
| txReady | input | 1 | Transmitter accepts the byte |
| txData | output | 8 | Frame byte |
| txFirst | output | 1 | Byte starts a frame |
| txLast | output | 1 | Byte ends a frame |
| txAbort | output | 1 | One-cycle pulse: the frame in progress is aborted by an underflow |
| txStatValid | input | 1 | Transmitter status is valid (after the last byte) |
| txStatBits | input | 17 | Transmitter status, in write-back bit positions 16:0 |
| txIrq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
The checks assume a memory that answers each request with a single-cycle memAck and returns read data in that same cycle. They also assume that txStatValid arrives only after the last byte of a last segment, and that software rewrites descriptors only while the engine sits in Suspended. The bench keeps to these rules. Its memory model acknowledges every other cycle. Its transmitter pulses status two cycles after it sees txLast. Descriptor updates are made only after the engine has been quiet for thirty cycles. txReady follows a fixed two-of-three pattern, so the stalls exercise the data hold checks.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int IRQ_BIT      = 30;
  localparam int LS_BIT       = 29;
  localparam int FS_BIT       = 28;
  localparam int RING_END_BIT = 21;
  localparam int CHAIN_BIT    = 20;
  localparam int DESC_STRIDE  = 32;
  localparam logic [16:0] ES_MASK   = 17'h17F06;
  localparam logic [16:0] KEEP_MASK = 17'h17FFF;
  localparam logic [2:0]  SEL_BUF   = 3'd4;

  typedef enum logic [3:0] {
    S_SUSP, S_RD0, S_RD1, S_RD2, S_RD3, S_CHK, S_DRD, S_DOUT, S_WSTAT, S_WB
  } dmaState_e;

  typedef struct packed {
    logic [2:0] addrSel;
    logic       ldW0;
    logic       ldW1;
    logic       ldW2;
    logic       ldW3;
    logic       ldData;
    logic       emitByte;
    logic       ldStat;
    logic       setUf;
    logic       advance;
  } dmaStrobe_t;
endpackage

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [31:0]       memRData,
  input  logic [16:0]       txStatBits,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  output logic [7:0]        txData,
  output logic              firstPend,
  output logic              lastSeg,
  output logic              irqReq,
  output logic              sizeZero,
  output logic              underflowCase,
  output logic              lastByte,
  output logic              wordEnd
);
  logic [ADDR_W-1:0] curAddr, bufPtr, nextPtr, nextDesc;
  logic [30:17]      ctlHi;
  logic [SIZE_W-1:0] bufLeft;
  logic [31:0]       dataWord;
  logic [1:0]        byteIdx;
  logic [16:0]       statField;
  logic              esBit;

  always_comb begin
    if (ctlHi[RING_END_BIT])   nextDesc = listBase;
    else if (ctlHi[CHAIN_BIT]) nextDesc = nextPtr;
    else                       nextDesc = curAddr + ADDR_W'(DESC_STRIDE);
  end

  assign memAddr  = (stb.addrSel == SEL_BUF) ? bufPtr
                  : curAddr + ADDR_W'({stb.addrSel[1:0], 2'b00});
  assign esBit    = |(statField & ES_MASK);
  assign memWData = {1'b0, ctlHi, statField[16], esBit, statField[14:0]};
  assign txData   = dataWord[8*byteIdx +: 8];

  assign lastSeg       = ctlHi[LS_BIT];
  assign irqReq        = ctlHi[IRQ_BIT] & ctlHi[LS_BIT];
  assign sizeZero      = (bufLeft == '0);
  assign underflowCase = sizeZero & (~ctlHi[FS_BIT] | ctlHi[LS_BIT]);
  assign lastByte      = (bufLeft == SIZE_W'(1));
  assign wordEnd       = (byteIdx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= listBase;
      bufPtr    <= '0;
      nextPtr   <= '0;
      ctlHi     <= '0;
      bufLeft   <= '0;
      dataWord  <= '0;
      byteIdx   <= '0;
      statField <= '0;
      firstPend <= 1'b0;
    end else begin
      if (stb.ldW0) begin
        ctlHi     <= memRData[30:17];
        statField <= '0;
        if (memRData[31] && memRData[FS_BIT]) firstPend <= 1'b1;
      end
      if (stb.ldW1) bufLeft <= memRData[SIZE_W-1:0];
      if (stb.ldW2) begin
        bufPtr  <= memRData[ADDR_W-1:0];
        byteIdx <= '0;
      end
      if (stb.ldW3)   nextPtr  <= memRData[ADDR_W-1:0];
      if (stb.ldData) dataWord <= memRData;
      if (stb.emitByte) begin
        byteIdx   <= byteIdx + 2'd1;
        bufLeft   <= bufLeft - SIZE_W'(1);
        firstPend <= 1'b0;
        if (byteIdx == 2'd3) bufPtr <= bufPtr + ADDR_W'(4);
      end
      if (stb.ldStat) statField <= statField | (txStatBits & KEEP_MASK);
      if (stb.setUf) begin
        statField[1] <= 1'b1;
        firstPend    <= 1'b0;
      end
      if (stb.advance) curAddr <= nextDesc;
    end
  end
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollReq,
  input  logic       memAck,
  input  logic       memRdOwn,
  input  logic       txReady,
  input  logic       txStatValid,
  input  logic       lastSeg,
  input  logic       irqReq,
  input  logic       sizeZero,
  input  logic       underflowCase,
  input  logic       lastByte,
  input  logic       wordEnd,
  output dmaStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       txAbort,
  output logic       txIrq
);
  dmaState_e state, nxt;
  logic      ufHit;

  always_comb begin
    stb     = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txValid = 1'b0;
    txAbort = 1'b0;
    nxt     = state;
    case (state)
      S_SUSP: if (pollReq) nxt = S_RD0;
      S_RD0: begin
        memReq = 1'b1;
        stb.addrSel = 3'd0;
        if (memAck) begin
          stb.ldW0 = 1'b1;
          nxt = memRdOwn ? S_RD1 : S_SUSP;
        end
      end
      S_RD1: begin
        memReq = 1'b1;
        stb.addrSel = 3'd1;
        if (memAck) begin stb.ldW1 = 1'b1; nxt = S_RD2; end
      end
      S_RD2: begin
        memReq = 1'b1;
        stb.addrSel = 3'd2;
        if (memAck) begin stb.ldW2 = 1'b1; nxt = S_RD3; end
      end
      S_RD3: begin
        memReq = 1'b1;
        stb.addrSel = 3'd3;
        if (memAck) begin stb.ldW3 = 1'b1; nxt = S_CHK; end
      end
      S_CHK: begin
        if (underflowCase) begin
          stb.setUf = 1'b1;
          txAbort   = 1'b1;
          nxt       = S_WB;
        end else if (sizeZero) nxt = S_WB;
        else                   nxt = S_DRD;
      end
      S_DRD: begin
        memReq = 1'b1;
        stb.addrSel = SEL_BUF;
        if (memAck) begin stb.ldData = 1'b1; nxt = S_DOUT; end
      end
      S_DOUT: begin
        txValid = 1'b1;
        stb.addrSel = SEL_BUF;
        if (txReady) begin
          stb.emitByte = 1'b1;
          if (lastByte)     nxt = lastSeg ? S_WSTAT : S_WB;
          else if (wordEnd) nxt = S_DRD;
        end
      end
      S_WSTAT: if (txStatValid) begin stb.ldStat = 1'b1; nxt = S_WB; end
      S_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.addrSel = 3'd0;
        if (memAck) begin
          stb.advance = 1'b1;
          nxt = ufHit ? S_SUSP : S_RD0;
        end
      end
      default: nxt = S_SUSP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_SUSP;
      ufHit <= 1'b0;
      txIrq <= 1'b0;
    end else begin
      state <= nxt;
      txIrq <= (state == S_WB) && memAck && (irqReq || ufHit);
      if (state == S_CHK && underflowCase)  ufHit <= 1'b1;
      else if (state == S_WB && memAck)     ufHit <= 1'b0;
    end
  end

  // R6
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              pollReq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic              memAck,
  input  logic [31:0]       memRData,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txFirst,
  output logic              txLast,
  output logic              txAbort,
  input  logic              txStatValid,
  input  logic [16:0]       txStatBits,
  output logic              txIrq
);
  dmaStrobe_t stb;
  logic firstPend, lastSeg, irqReq, sizeZero, underflowCase, lastByte, wordEnd;

  txdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pollReq(pollReq), .memAck(memAck),
    .memRdOwn(memRData[31]), .txReady(txReady), .txStatValid(txStatValid),
    .lastSeg(lastSeg), .irqReq(irqReq), .sizeZero(sizeZero),
    .underflowCase(underflowCase), .lastByte(lastByte), .wordEnd(wordEnd),
    .stb(stb), .memReq(memReq), .memWe(memWe), .txValid(txValid),
    .txAbort(txAbort), .txIrq(txIrq)
  );

  txdma_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .listBase(listBase),
    .memRData(memRData), .txStatBits(txStatBits), .memAddr(memAddr),
    .memWData(memWData), .txData(txData), .firstPend(firstPend),
    .lastSeg(lastSeg), .irqReq(irqReq), .sizeZero(sizeZero),
    .underflowCase(underflowCase), .lastByte(lastByte), .wordEnd(wordEnd)
  );

  assign txFirst = firstPend & txValid;
  assign txLast  = lastSeg & lastByte & txValid;

  // R1
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R2
  tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));

  // R4
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWData[31]);
endmodule

// File: tb/txdma_engine_tb_top.sv
module txdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] listBase;
  logic        pollReq;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWData, memRData;
  logic        txValid, txReady, txFirst, txLast, txAbort, txStatValid, txIrq;
  logic [7:0]  txData;
  logic [16:0] txStatBits;

  logic [31:0] mem [0:255];
  logic [16:0] statQ [0:15];
  logic [7:0]  rxD [0:63];
  logic        rxF [0:63];
  logic        rxL [0:63];
  logic [7:0]  expD [0:63];
  logic        expF [0:63];
  logic        expL [0:63];
  int rxCnt = 0, expCnt = 0, statIdx = 0, statDelay = 0;
  int irqCnt = 0, abortCnt = 0, cyc = 0;
  int nChk = 0, nFail = 0;
  int hostSeq = 0, hostIdx = 0;
  logic [31:0] hostData = 0;

  always #5 clk = ~clk;

  txdma_engine dut_i (
    .clk(clk), .rstN(rstN), .listBase(listBase), .pollReq(pollReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txFirst(txFirst), .txLast(txLast), .txAbort(txAbort),
    .txStatValid(txStatValid), .txStatBits(txStatBits), .txIrq(txIrq)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 7) & 255);
  endfunction

  function automatic logic [31:0] wbExp(logic [31:0] w0, logic [16:0] st);
    logic [31:0] r;
    r = {w0[31:17], st};
    r[31] = 1'b0;
    r[15] = |(st & 17'h17F06);
    return r;
  endfunction

  // memory model: only writer of mem
  initial begin
    int lastSeq;
    lastSeq = 0;
    memAck = 1'b0;
    memRData = '0;
    for (int w = 0; w < 256; w++)
      mem[w] = (w < 128) ? 32'h0 : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    forever begin
      @(negedge clk);
      if (hostSeq != lastSeq) begin
        mem[hostIdx] = hostData;
        lastSeq = hostSeq;
      end
      if (memAck) memAck = 1'b0;
      else if (memReq && rstN) begin
        memAck = 1'b1;
        if (memWe) mem[memAddr[9:2]] = memWData;
        else       memRData = mem[memAddr[9:2]];
      end
    end
  end

  // transmitter model and event monitor
  initial begin
    logic rdy;
    txReady = 1'b0;
    txStatValid = 1'b0;
    txStatBits = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (statDelay == 1) begin
        txStatValid = 1'b1;
        txStatBits = statQ[statIdx];
        statIdx++;
        statDelay = 0;
      end else begin
        txStatValid = 1'b0;
        if (statDelay > 1) statDelay--;
      end
      rdy = (cyc % 3) != 2;
      if (txValid && rdy && rstN) begin
        if (rxCnt < 64) begin
          rxD[rxCnt] = txData;
          rxF[rxCnt] = txFirst;
          rxL[rxCnt] = txLast;
        end
        rxCnt++;
        if (txLast) statDelay = 2;
      end
      txReady = rdy;
      if (txIrq) irqCnt++;
      if (txAbort) abortCnt++;
    end
  end

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic hostWrite(int idx, logic [31:0] d);
    @(posedge clk);
    hostIdx = idx;
    hostData = d;
    hostSeq++;
    @(posedge clk);
  endtask

  task automatic setDesc(int a, logic [31:0] w0, logic [31:0] w1,
                         logic [31:0] w2, logic [31:0] w3);
    hostWrite(a/4, w0);
    hostWrite(a/4 + 1, w1);
    hostWrite(a/4 + 2, w2);
    hostWrite(a/4 + 3, w3);
  endtask

  task automatic clearDescs();
    for (int w = 0; w < 128; w++) if (mem[w] != 0) hostWrite(w, 32'h0);
  endtask

  task automatic addExp(int b, int n, bit fs, bit ls);
    for (int j = 0; j < n; j++) begin
      expD[expCnt] = pat(b + j);
      expF[expCnt] = fs && (j == 0);
      expL[expCnt] = ls && (j == n - 1);
      expCnt++;
    end
  endtask

  task automatic checkStream(string rq);
    check(rxCnt == expCnt, rq, rxCnt, expCnt);
    for (int i = 0; i < expCnt && i < rxCnt && i < 64; i++)
      check(rxD[i] == expD[i] && rxF[i] == expF[i] && rxL[i] == expL[i], rq,
            {22'h0, rxF[i], rxL[i], rxD[i]}, {22'h0, expF[i], expL[i], expD[i]});
    rxCnt = 0;
    expCnt = 0;
  endtask

  task automatic poll();
    @(negedge clk); pollReq = 1'b1;
    @(negedge clk); pollReq = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet;
    quiet = 0;
    while (quiet < 30) begin
      @(negedge clk);
      if (memReq || txValid || txStatValid || statDelay != 0) quiet = 0;
      else quiet++;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    finishRun();
  end

  initial begin
    logic [31:0] w0;
    bit sawReq;
    rstN = 1'b0;
    pollReq = 1'b0;
    listBase = 32'h0;
    statQ[0] = 17'h10000; statQ[1] = 17'h04000; statQ[2] = 17'h02000;
    statQ[3] = 17'h01000; statQ[4] = 17'h00800; statQ[5] = 17'h00200;
    statQ[6] = 17'h00002; statQ[7] = 17'h00080; statQ[8] = 17'h00100;
    statQ[9] = 17'h00000;
    for (int i = 10; i < 16; i++) statQ[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9: idle after reset, no fetch before a poll
    sawReq = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (memReq || txValid || txIrq) sawReq = 1'b1;
    end
    check(!sawReq, "R9 idle after reset", {31'h0, sawReq}, 32'h0);

    // R1: host-owned descriptor -> nothing sent, nothing written
    poll();
    waitIdle();
    check(rxCnt == 0 && irqCnt == 0, "R1 host-owned skipped", rxCnt, 0);
    check(mem[0] == 32'h0, "R1 no write-back", mem[0], 32'h0);

    // R2 R3 R4 R5 R6 R7: size sweep 1..8, sequential walk, ring end on last
    for (int k = 0; k < 8; k++) begin
      w0 = 32'hF000_0000 | ((k == 7) ? 32'h0020_0000 : 32'h0)
                         | ((k % 2) ? 32'h0800_0000 : 32'h0);
      setDesc(32*k, w0, k + 1, 32'h200 + 16*k, 32'h0);
      addExp(32'h200 + 16*k, k + 1, 1'b1, 1'b1);
    end
    poll();
    waitIdle();
    checkStream("R2 R3 sweep stream");
    for (int k = 0; k < 8; k++) begin
      w0 = 32'hF000_0000 | ((k == 7) ? 32'h0020_0000 : 32'h0)
                         | ((k % 2) ? 32'h0800_0000 : 32'h0);
      check(mem[8*k] == wbExp(w0, statQ[k]), "R4 R5 write-back", mem[8*k],
            wbExp(w0, statQ[k]));
    end
    check(irqCnt == 8, "R6 one irq per last segment", irqCnt, 8);

    // R7 R3 R6: chained scatter-gather, ring end wins over chain
    clearDescs();
    setDesc(32'h000, 32'hD010_0000, 2, 32'h200, 32'h100);
    setDesc(32'h100, 32'hE030_0000, 3, 32'h240, 32'h140);
    setDesc(32'h140, 32'hF000_0000, 1, 32'h280, 32'h0);
    addExp(32'h200, 2, 1'b1, 1'b0);
    addExp(32'h240, 3, 1'b0, 1'b1);
    poll();
    waitIdle();
    checkStream("R3 R7 chained frame");
    check(mem[0] == wbExp(32'hD010_0000, 17'h0), "R4 middle write-back",
          mem[0], wbExp(32'hD010_0000, 17'h0));
    check(mem[64] == wbExp(32'hE030_0000, statQ[8]), "R5 last write-back",
          mem[64], wbExp(32'hE030_0000, statQ[8]));
    check(mem[80] == 32'hF000_0000, "R7 ring end over chain", mem[80], 32'hF000_0000);
    check(irqCnt == 9, "R6 irq ignored on non-last", irqCnt, 9);

    // R8: underflow mid-frame, then suspend and resume
    clearDescs();
    setDesc(32'h00, 32'h9000_0000, 4, 32'h2C0, 32'h0);
    setDesc(32'h20, 32'h8000_0000, 0, 32'h300, 32'h0);
    setDesc(32'h40, 32'hF000_0000, 1, 32'h310, 32'h0);
    addExp(32'h2C0, 4, 1'b1, 1'b0);
    poll();
    waitIdle();
    checkStream("R8 partial frame");
    check(abortCnt == 1, "R8 abort pulse", abortCnt, 1);
    check(mem[0] == wbExp(32'h9000_0000, 17'h0), "R4 first segment write-back",
          mem[0], wbExp(32'h9000_0000, 17'h0));
    check(mem[8] == wbExp(32'h8000_0000, 17'h00002), "R8 underflow status",
          mem[8], wbExp(32'h8000_0000, 17'h00002));
    check(irqCnt == 10, "R8 underflow irq", irqCnt, 10);
    check(mem[16] == 32'hF000_0000, "R8 suspended after underflow",
          mem[16], 32'hF000_0000);
    addExp(32'h310, 1, 1'b1, 1'b1);
    poll();
    waitIdle();
    checkStream("R8 resume stream");
    check(irqCnt == 11, "R8 resume irq", irqCnt, 11);
    check(mem[16] == wbExp(32'hF000_0000, statQ[9]), "R8 resume write-back",
          mem[16], wbExp(32'hF000_0000, statQ[9]));
    check(abortCnt == 1, "R8 no extra abort", abortCnt, 1);

    finishRun();
  end
endmodule